// File: doc/BRIEF.md
# Key Slot Usage-Policy Controller

This block holds a small bank of key slots on behalf of a cipher engine. Each slot carries a secret key, a mask of the operations it may serve, a count of the uses it has left, a seal state, and a flag that says whether only privileged callers may use it. A management port installs, seals, unseals and erases slots. A use port takes key requests from the engine. Each request is checked against the slot's policy and counter in the same cycle. The block then either hands out the key and spends one use, or refuses the request, raises an alert and tells the engine to abort.

Sealing and unsealing require a match against an identifier fixed at boot. Two panic levels exist. The soft level freezes all traffic but keeps every key. The hard level wipes every key and empties every slot in a single cycle.

The use port is a valid/ready stream. `use_ready` drops whenever a panic level is active or a management command is present on the same cycle. A request is taken only on a cycle where both `use_valid` and `use_ready` are high. Its answer appears as a one-cycle pulse on `grant_valid` or `alert` on the next cycle. That answer cannot be stalled.

The management port has no ready signal. Every cycle with `mgmt_valid` high is consumed. It is answered one cycle later by a pulse on `mgmt_ok` or on `mgmt_err`.

Top module: `keyslot_guard`

## Requirements
- R1: After reset every slot reads EMPTY, coded 0 in its 2-bit field of `slot_state` (field i at bits 2i+1:2i; LOADED=1, SEALED=2, EXHAUSTED=3). `grant_valid`, `alert`, `abort_all` and `alert_count` are 0, and `use_ready` is 1.
- R2: An install (`mgmt_op`=0) succeeds only when the caller is privileged, the slot is EMPTY and the use limit is nonzero. The slot then becomes LOADED. Any other install gives `mgmt_err` and an alert, and leaves the slot unchanged.
- R3: A request accepted on a cycle gives `grant_valid` with the slot's key on the next cycle when all of the following hold: the slot is LOADED, bit `use_op` of its allowed-operation mask is set, and its privilege rule is met. Whenever `grant_valid` is low, `grant_key` is all zero.
- R4: A request for an operation whose mask bit is clear is refused. No grant is given, `alert` and `abort_all` pulse, and the use count is not spent.
- R5: Each grant spends one use. The grant that spends the last use moves the slot to EXHAUSTED, and an EXHAUSTED slot refuses every request, including one issued back to back right after the last grant.
- R6: A slot installed with `mgmt_need_priv` set refuses requests with `use_priv` low and serves requests with `use_priv` high.
- R7: Seal (`mgmt_op`=1, LOADED to SEALED) and unseal (`mgmt_op`=2, SEALED to LOADED) succeed only when `mgmt_uid` equals `boot_uid`. A SEALED slot refuses all use requests.
- R8: Erase (`mgmt_op`=3) needs a privileged caller. It returns the slot to EMPTY and clears its key, and a later request to that slot is refused with a zero key.
- R9: With `panic_lvl`=1, `use_ready` is low, every management command is refused with `mgmt_err`, and `abort_all` is high. Keys and counts are kept, so a slot serves again once the level returns to 0.
- R10: With `panic_lvl` of 2 or 3, every slot reads EMPTY after the next clock edge and its key is cleared. Slots can be installed again once the level returns to 0.
- R11: Each refused command or request raises `alert` for one cycle and adds one to `alert_count`, which saturates at its all-ones value.
- R12: `use_ready` is low on any cycle where `mgmt_valid` is high, and a request presented on that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_uid | input | ID_W | Identifier fixed at boot, needed to seal and unseal |
| panic_lvl | input | 2 | 0 none, 1 soft (keep keys), 2 or 3 hard (wipe keys) |
| mgmt_valid | input | 1 | Management command present |
| mgmt_op | input | 2 | 0 install, 1 seal, 2 unseal, 3 erase |
| mgmt_slot | input | SL_W | Target slot of the command |
| mgmt_priv | input | 1 | Caller is privileged |
| mgmt_key | input | KEY_W | Key to install |
| mgmt_limit | input | CNT_W | Number of uses to allow |
| mgmt_allow | input | OPS | Allowed-operation mask, bit i allows operation i |
| mgmt_need_priv | input | 1 | Slot will serve privileged requests only |
| mgmt_uid | input | ID_W | Identifier offered for seal or unseal |
| mgmt_ok | output | 1 | Command accepted (one-cycle pulse) |
| mgmt_err | output | 1 | Command refused (one-cycle pulse) |
| use_valid | input | 1 | Key request present |
| use_ready | output | 1 | Request can be taken this cycle |
| use_slot | input | SL_W | Requested slot |
| use_op | input | OP_W | Requested operation index |
| use_priv | input | 1 | Requester is privileged |
| grant_valid | output | 1 | Request granted (one-cycle pulse) |
| grant_key | output | KEY_W | Key for the granted request, zero otherwise |
| alert | output | 1 | Misuse detected (one-cycle pulse) |
| abort_all | output | 1 | Engine must abort its ongoing operations |
| alert_count | output | LOG_W | Saturating count of misuse events |
| slot_state | output | 2*NSLOT | Per-slot state codes |

## Verification
The bench builds the block with four slots, a 4-bit use counter and a 3-bit misuse log. The short counter lets a slot run out of uses in a handful of requests, including a back-to-back pair on the last remaining use. The 3-bit log fills after seven refusals, so its saturation is reached within the main vector walk. Four operation indices and the 16-bit identifier are enough to cover both a mode-bound slot and a direction-bound slot, as well as a mismatched identifier.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY  = 2'd0,
    SLOT_LOADED = 2'd1,
    SLOT_SEALED = 2'd2,
    SLOT_SPENT  = 2'd3
  } slot_st_e;

  typedef enum logic [1:0] {
    MG_INSTALL = 2'd0,
    MG_SEAL    = 2'd1,
    MG_UNSEAL  = 2'd2,
    MG_ERASE   = 2'd3
  } mgmt_op_e;

endpackage

// File: rtl/keyslot_slot.sv
module keyslot_slot
  import keyslot_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int CNT_W = 8,
  parameter int OPS   = 4,
  localparam int OP_W = $clog2(OPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             mg_fire,
  input  mgmt_op_e         mg_op,
  input  logic             mg_priv,
  input  logic [KEY_W-1:0] mg_key,
  input  logic [CNT_W-1:0] mg_limit,
  input  logic [OPS-1:0]   mg_allow,
  input  logic             mg_need_priv,
  input  logic             uid_ok,
  input  logic             use_fire,
  input  logic [OP_W-1:0]  use_op,
  input  logic             use_priv,
  output slot_st_e         st,
  output logic [KEY_W-1:0] key,
  output logic             mg_pass,
  output logic             use_pass
);

  logic [CNT_W-1:0] left;
  logic [OPS-1:0]   allow;
  logic             need_priv;

  always_comb begin
    unique case (mg_op)
      MG_INSTALL: mg_pass = mg_priv && (st == SLOT_EMPTY) && (mg_limit != '0);
      MG_SEAL:    mg_pass = uid_ok && (st == SLOT_LOADED);
      MG_UNSEAL:  mg_pass = uid_ok && (st == SLOT_SEALED);
      default:    mg_pass = mg_priv;
    endcase
  end

  assign use_pass = (st == SLOT_LOADED) && allow[use_op] && (!need_priv || use_priv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SLOT_EMPTY;
      key       <= '0;
      left      <= '0;
      allow     <= '0;
      need_priv <= 1'b0;
    end else if (flush) begin
      st        <= SLOT_EMPTY;
      key       <= '0;
      left      <= '0;
      allow     <= '0;
      need_priv <= 1'b0;
    end else if (mg_fire && mg_pass) begin
      unique case (mg_op)
        MG_INSTALL: begin
          st        <= SLOT_LOADED;
          key       <= mg_key;
          left      <= mg_limit;
          allow     <= mg_allow;
          need_priv <= mg_need_priv;
        end
        MG_SEAL:   st <= SLOT_SEALED;
        MG_UNSEAL: st <= SLOT_LOADED;
        default: begin
          st        <= SLOT_EMPTY;
          key       <= '0;
          left      <= '0;
          allow     <= '0;
          need_priv <= 1'b0;
        end
      endcase
    end else if (use_fire && use_pass) begin
      left <= left - 1'b1;
      if (left == {{(CNT_W-1){1'b0}}, 1'b1}) st <= SLOT_SPENT;
    end
  end

  AST_LAST_USE_SPENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (use_fire && use_pass && !mg_fire && !flush && left == {{(CNT_W-1){1'b0}}, 1'b1})
      |=> (st == SLOT_SPENT)); // R5

  AST_FLUSH_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (st == SLOT_EMPTY && key == '0)); // R10

  AST_SEALED_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SLOT_SEALED && !mg_fire && !flush) |=> ($stable(key) && st == SLOT_SEALED)); // R7

endmodule

// File: rtl/keyslot_alarm.sv
module keyslot_alarm #(
  parameter int LOG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             misuse,
  output logic             alert_o,
  output logic [LOG_W-1:0] count_o
);

  localparam logic [LOG_W-1:0] TOP = {LOG_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_o <= 1'b0;
      count_o <= '0;
    end else begin
      alert_o <= misuse;
      if (misuse && count_o != TOP) count_o <= count_o + 1'b1;
    end
  end

  AST_LOG_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (misuse && count_o != TOP) |=> (count_o == $past(count_o) + 1'b1)); // R11

  AST_LOG_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == TOP) |=> (count_o == TOP)); // R11

endmodule

// File: rtl/keyslot_guard.sv
module keyslot_guard
  import keyslot_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int KEY_W = 32,
  parameter int CNT_W = 8,
  parameter int OPS   = 4,
  parameter int ID_W  = 16,
  parameter int LOG_W = 8,
  localparam int SL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int OP_W = $clog2(OPS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    boot_uid,
  input  logic [1:0]         panic_lvl,
  input  logic               mgmt_valid,
  input  logic [1:0]         mgmt_op,
  input  logic [SL_W-1:0]    mgmt_slot,
  input  logic               mgmt_priv,
  input  logic [KEY_W-1:0]   mgmt_key,
  input  logic [CNT_W-1:0]   mgmt_limit,
  input  logic [OPS-1:0]     mgmt_allow,
  input  logic               mgmt_need_priv,
  input  logic [ID_W-1:0]    mgmt_uid,
  output logic               mgmt_ok,
  output logic               mgmt_err,
  input  logic               use_valid,
  output logic               use_ready,
  input  logic [SL_W-1:0]    use_slot,
  input  logic [OP_W-1:0]    use_op,
  input  logic               use_priv,
  output logic               grant_valid,
  output logic [KEY_W-1:0]   grant_key,
  output logic               alert,
  output logic               abort_all,
  output logic [LOG_W-1:0]   alert_count,
  output logic [2*NSLOT-1:0] slot_state
);

  logic panic_any, panic_hard, use_fire, mg_fire, uid_ok;
  logic mg_pass_sel, use_pass_sel, mg_good, use_good, misuse;
  logic [NSLOT-1:0] mg_pass_v, use_pass_v;
  logic [KEY_W-1:0] key_v [NSLOT];
  slot_st_e         st_v  [NSLOT];
  mgmt_op_e         op_e;

  assign panic_any  = (panic_lvl != 2'd0);
  assign panic_hard = panic_lvl[1];
  assign use_ready  = !panic_any && !mgmt_valid;
  assign use_fire   = use_valid && use_ready;
  assign mg_fire    = mgmt_valid && !panic_any;
  assign uid_ok     = (mgmt_uid == boot_uid);
  assign op_e       = mgmt_op_e'(mgmt_op);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    keyslot_slot #(
      .KEY_W(KEY_W), .CNT_W(CNT_W), .OPS(OPS)
    ) i_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (panic_hard),
      .mg_fire     (mg_fire && (mgmt_slot == SL_W'(i))),
      .mg_op       (op_e),
      .mg_priv     (mgmt_priv),
      .mg_key      (mgmt_key),
      .mg_limit    (mgmt_limit),
      .mg_allow    (mgmt_allow),
      .mg_need_priv(mgmt_need_priv),
      .uid_ok      (uid_ok),
      .use_fire    (use_fire && (use_slot == SL_W'(i))),
      .use_op      (use_op),
      .use_priv    (use_priv),
      .st          (st_v[i]),
      .key         (key_v[i]),
      .mg_pass     (mg_pass_v[i]),
      .use_pass    (use_pass_v[i])
    );
    assign slot_state[2*i +: 2] = st_v[i];
  end

  assign mg_pass_sel  = mg_pass_v[mgmt_slot];
  assign use_pass_sel = use_pass_v[use_slot];
  assign mg_good      = mg_fire && mg_pass_sel;
  assign use_good     = use_fire && use_pass_sel;
  assign misuse       = (mgmt_valid && !mg_good) || (use_fire && !use_pass_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mgmt_ok     <= 1'b0;
      mgmt_err    <= 1'b0;
      grant_valid <= 1'b0;
      grant_key   <= '0;
      abort_all   <= 1'b0;
    end else begin
      mgmt_ok     <= mg_good;
      mgmt_err    <= mgmt_valid && !mg_good;
      grant_valid <= use_good;
      grant_key   <= use_good ? key_v[use_slot] : '0;
      abort_all   <= misuse || panic_any;
    end
  end

  keyslot_alarm #(.LOG_W(LOG_W)) i_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .misuse (misuse),
    .alert_o(alert),
    .count_o(alert_count)
  );

  AST_GRANT_NOT_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !alert); // R4

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(use_valid && use_ready)); // R3

  AST_KEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_key == '0)); // R3

  AST_PANIC_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (panic_lvl != 2'd0 || mgmt_valid) |-> !use_ready); // R12

  AST_PANIC_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (panic_lvl != 2'd0) |=> !grant_valid && !mgmt_ok); // R9

endmodule

// File: tb/test_keyslot_guard.sv
`timescale 1ns/100ps
module test_keyslot_guard;

  localparam int NSLOT = 4, KEY_W = 32, CNT_W = 4, OPS = 4, ID_W = 16, LOG_W = 3;
  localparam logic [ID_W-1:0] BOOT = 16'h5A3C;
  localparam logic [LOG_W-1:0] LOG_TOP = {LOG_W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] panic_lvl = '0;
  logic mgmt_valid = 0, mgmt_priv = 0, mgmt_need_priv = 0, use_valid = 0, use_priv = 0;
  logic [1:0] mgmt_op = '0, mgmt_slot = '0, use_slot = '0, use_op = '0;
  logic [KEY_W-1:0] mgmt_key = '0;
  logic [CNT_W-1:0] mgmt_limit = '0;
  logic [OPS-1:0] mgmt_allow = '0;
  logic [ID_W-1:0] mgmt_uid = '0;
  logic mgmt_ok, mgmt_err, use_ready, grant_valid, alert, abort_all;
  logic [KEY_W-1:0] grant_key;
  logic [LOG_W-1:0] alert_count;
  logic [2*NSLOT-1:0] slot_state;

  int errors = 0, checks = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  keyslot_guard #(.NSLOT(NSLOT), .KEY_W(KEY_W), .CNT_W(CNT_W), .OPS(OPS),
                  .ID_W(ID_W), .LOG_W(LOG_W)) i_keyslot_guard (
    .clk(clk), .rst_n(rst_n), .boot_uid(BOOT), .panic_lvl(panic_lvl),
    .mgmt_valid(mgmt_valid), .mgmt_op(mgmt_op), .mgmt_slot(mgmt_slot),
    .mgmt_priv(mgmt_priv), .mgmt_key(mgmt_key), .mgmt_limit(mgmt_limit),
    .mgmt_allow(mgmt_allow), .mgmt_need_priv(mgmt_need_priv), .mgmt_uid(mgmt_uid),
    .mgmt_ok(mgmt_ok), .mgmt_err(mgmt_err), .use_valid(use_valid),
    .use_ready(use_ready), .use_slot(use_slot), .use_op(use_op),
    .use_priv(use_priv), .grant_valid(grant_valid), .grant_key(grant_key),
    .alert(alert), .abort_all(abort_all), .alert_count(alert_count),
    .slot_state(slot_state)
  );

  function automatic logic [KEY_W-1:0] key_of(input logic [1:0] s);
    return 32'hC0DE_0000 | {30'd0, s};
  endfunction

  // Vector layout: [22:19] req, [18] use, [17:16] op, [15:14] slot, [13] priv,
  // [12:9] limit, [8:5] allow, [4] need_priv, [3] uid good, [2] ok, [1:0] state after
  function automatic logic [22:0] mk(input int rq, input bit u, input int op, input int sl,
      input bit pv, input int lim, input int alw, input bit np, input bit ug,
      input bit ok, input int st);
    return {4'(rq), u, 2'(op), 2'(sl), pv, 4'(lim), 4'(alw), np, ug, ok, 2'(st)};
  endfunction

  localparam int NV = 20;
  localparam logic [22:0] VEC [NV] = '{
    mk(2, 0, 0, 0, 0, 3, 4'b0001, 0, 1, 0, 0), // R2 unprivileged install
    mk(2, 0, 0, 0, 1, 0, 4'b0001, 0, 1, 0, 0), // R2 zero limit
    mk(2, 0, 0, 0, 1, 3, 4'b0001, 0, 1, 1, 1), // R2 good install
    mk(2, 0, 0, 0, 1, 3, 4'b0001, 0, 1, 0, 1), // R2 install on loaded slot
    mk(3, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1),       // R3 grant
    mk(4, 1, 1, 0, 0, 0, 0, 0, 1, 0, 1),       // R4 op not allowed
    mk(5, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1),       // R5 second use
    mk(5, 1, 0, 0, 0, 0, 0, 0, 1, 1, 3),       // R5 last use spends slot
    mk(5, 1, 0, 0, 0, 0, 0, 0, 1, 0, 3),       // R5 back to back after last
    mk(6, 0, 0, 1, 1, 5, 4'b1100, 1, 1, 1, 1), // R6 install privileged-only slot
    mk(6, 1, 2, 1, 0, 0, 0, 0, 1, 0, 1),       // R6 unprivileged refused
    mk(6, 1, 3, 1, 1, 0, 0, 0, 1, 1, 1),       // R6 privileged served
    mk(7, 0, 1, 1, 0, 0, 0, 0, 0, 0, 1),       // R7 seal wrong uid
    mk(7, 0, 1, 1, 0, 0, 0, 0, 1, 1, 2),       // R7 seal
    mk(7, 1, 3, 1, 1, 0, 0, 0, 1, 0, 2),       // R7 sealed refuses use
    mk(7, 0, 2, 1, 0, 0, 0, 0, 1, 1, 1),       // R7 unseal
    mk(7, 1, 2, 1, 1, 0, 0, 0, 1, 1, 1),       // R7 serves again
    mk(8, 0, 3, 0, 0, 0, 0, 0, 1, 0, 3),       // R8 unprivileged erase
    mk(8, 0, 3, 0, 1, 0, 0, 0, 1, 1, 0),       // R8 erase
    mk(8, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0)        // R8 use after erase
  };

  task automatic chk(input bit cond, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic note_misuse(input bit bad);
    if (bad && exp_cnt < int'(LOG_TOP)) exp_cnt++;
  endtask

  task automatic run_one(input logic [22:0] v);
    string rq;
    logic [1:0] sl;
    bit ok;
    rq = $sformatf("R%0d", v[22:19]);
    sl = v[15:14];
    ok = v[2];
    @(negedge clk);
    if (v[18]) begin
      use_valid = 1; use_slot = sl; use_op = v[17:16]; use_priv = v[13];
    end else begin
      mgmt_valid = 1; mgmt_op = v[17:16]; mgmt_slot = sl; mgmt_priv = v[13];
      mgmt_key = key_of(sl); mgmt_limit = v[12:9]; mgmt_allow = v[8:5];
      mgmt_need_priv = v[4]; mgmt_uid = v[3] ? BOOT : (BOOT ^ 16'h0001);
    end
    @(posedge clk);
    @(negedge clk);
    note_misuse(!ok);
    if (v[18]) begin
      chk(grant_valid == ok, rq, grant_valid, ok);
      chk(grant_key == (ok ? key_of(sl) : '0), "R3", grant_key, ok ? key_of(sl) : '0);
    end else begin
      chk(mgmt_ok == ok && mgmt_err == !ok, rq, {mgmt_ok, mgmt_err}, {ok, !ok});
    end
    chk(alert == !ok && abort_all == !ok, "R4", {alert, abort_all}, {!ok, !ok});
    chk(alert_count == LOG_W'(exp_cnt), "R11", alert_count, exp_cnt);
    chk(slot_state[2*sl +: 2] == v[1:0], rq, slot_state[2*sl +: 2], v[1:0]);
    use_valid = 0; mgmt_valid = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(slot_state == '0, "R1", slot_state, 0);
    chk(!grant_valid && !alert && !abort_all, "R1", {grant_valid, alert, abort_all}, 0);
    chk(alert_count == '0, "R1", alert_count, 0);
    chk(use_ready == 1'b1, "R1", use_ready, 1);

    for (int k = 0; k < NV; k++) run_one(VEC[k]);
    chk(alert_count == LOG_TOP, "R11", alert_count, LOG_TOP);

    // R12: management present blocks the use port; request has no effect
    @(negedge clk);
    mgmt_valid = 1; mgmt_op = 2'd3; mgmt_slot = 2'd3; mgmt_priv = 0;
    use_valid = 1; use_slot = 2'd1; use_op = 2'd2; use_priv = 1;
    #1;
    chk(use_ready == 1'b0, "R12", use_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(!grant_valid && mgmt_err, "R12", {grant_valid, mgmt_err}, 2'b01);
    mgmt_valid = 0; use_valid = 0;

    // R9 soft panic keeps keys, blocks everything
    @(negedge clk);
    panic_lvl = 2'd1;
    mgmt_valid = 1; mgmt_op = 2'd0; mgmt_slot = 2'd2; mgmt_priv = 1;
    mgmt_key = key_of(2); mgmt_limit = 4'd2; mgmt_allow = 4'b0001;
    #1;
    chk(use_ready == 1'b0, "R9", use_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(mgmt_err && !mgmt_ok && abort_all, "R9", {mgmt_err, mgmt_ok, abort_all}, 3'b101);
    chk(slot_state[5:4] == 2'd0 && slot_state[3:2] == 2'd1, "R9", slot_state, 8'h04);
    mgmt_valid = 0; panic_lvl = 2'd0;
    run_one(mk(9, 1, 2, 1, 1, 0, 0, 0, 1, 1, 1)); // R9 slot 1 serves after soft panic

    // R10 hard panic wipes every slot in one edge
    @(negedge clk);
    panic_lvl = 2'd2;
    @(posedge clk); @(negedge clk);
    chk(slot_state == '0, "R10", slot_state, 0);
    chk(abort_all == 1'b1, "R10", abort_all, 1);
    panic_lvl = 2'd0;
    run_one(mk(10, 1, 2, 1, 1, 0, 0, 0, 1, 0, 0)); // R10 wiped slot refuses
    run_one(mk(10, 0, 0, 2, 1, 2, 4'b0001, 0, 1, 1, 1)); // R10 install again
    run_one(mk(10, 1, 0, 2, 0, 0, 0, 0, 1, 1, 1)); // R10 new key served

    summary();
    $finish;
  end

endmodule